// File: doc/BRIEF.md
# Multi-Cycle Shared-Memory Processor Datapath

This block is the datapath half of a 32-bit load/store processor that completes each instruction over several clock cycles. A single memory port serves both instruction fetch and data access, and a single ALU does every addition: the program-counter increment, the branch target and the load/store address. Holding registers between the steps carry values from one cycle to the next. These are the instruction register, a data register, two operand registers and an ALU result register.

A separate sequencer drives the block. Each cycle it supplies the register enables, the multiplexer selects and a 3-bit ALU operation. The datapath returns the opcode and function fields of the held instruction and the ALU zero flag. The memory sits outside the block on a simple combinational-read, clocked-write port.

Top module: `mc_datapath`

## Requirements
- R1: A synchronous active-high `rst` sets the program counter to 0. After reset, with `addr_sel`=0, `mem_addr` reads 0.
- R2: `mem_addr` is the program counter when `addr_sel`=0 and the registered ALU result when `addr_sel`=1. The memory model decodes it as a word address using bits 31:2.
- R3: The instruction register loads `mem_rdata` only in cycles where `ir_ld`=1; otherwise it holds. `op_field` is instruction bits 31:26 and `fn_field` is bits 5:0.
- R4: Register-file read ports are addressed by instruction bits 25:21 and 20:16, and both operand registers reload every cycle. Register 0 always reads as zero, and writes to it are discarded.
- R5: When `rf_we`=1, the register written is bits 20:16 (`rd_sel`=0) or bits 15:11 (`rd_sel`=1). The value written is the registered ALU result (`wb_sel`=0) or the data register (`wb_sel`=1), which captures `mem_rdata` every cycle.
- R6: ALU operand A is the program counter when `opa_sel`=0 and the first operand register when `opa_sel`=1.
- R7: ALU operand B follows `opb_sel`: 00 gives the second operand register, 01 the constant 4, 10 the sign-extended 16-bit immediate (bits 15:0), and 11 that immediate shifted left by two.
- R8: `alu_op` codes: 010 add, 110 subtract, 000 AND, 001 OR, 111 signed set-less-than (result 1 or 0). `alu_zero` is 1 exactly when the ALU result is 0.
- R9: The next program counter follows `npc_sel`: 00 gives the live ALU result, 01 the registered ALU result, and 10 the jump target. The jump target is PC bits 31:28, then instruction bits 25:0, then two zero bits.
- R10: The program counter updates only when `pc_wr`=1, or when `br_cond`=1 and `alu_zero`=1.
- R11: `mem_wdata` is the second operand register, and `mem_wr` follows `st_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_wr | input | 1 | Unconditional program-counter update |
| br_cond | input | 1 | Update program counter if ALU result is zero |
| ir_ld | input | 1 | Instruction register load enable |
| addr_sel | input | 1 | Memory address source: 0 PC, 1 registered ALU result |
| st_en | input | 1 | Memory write request |
| rf_we | input | 1 | Register-file write enable |
| rd_sel | input | 1 | Destination field: 0 bits 20:16, 1 bits 15:11 |
| wb_sel | input | 1 | Write-back source: 0 ALU result register, 1 data register |
| opa_sel | input | 1 | ALU operand A: 0 PC, 1 operand register A |
| opb_sel | input | 2 | ALU operand B select |
| npc_sel | input | 2 | Next program counter select |
| alu_op | input | 3 | ALU operation code |
| mem_rdata | input | 32 | Memory read data |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_wr | output | 1 | Memory write strobe |
| op_field | output | 6 | Instruction bits 31:26 |
| fn_field | output | 6 | Instruction bits 5:0 |
| alu_zero | output | 1 | ALU result equals zero |

## Verification
The bench acts as the sequencer and runs a short program of loads, register-register operations, immediate adds, stores, two compare-and-branch instructions and a jump. The stored results tell each ALU operation and each operand-B source apart. A negative operand separates signed from unsigned compare and sign extension from zero extension. An immediate add aimed at register 0, followed by a store of register 0, separates a discarded write from a real one. One branch with unequal operands and one with equal operands show a held counter versus a loaded target, and skipped store slots confirm that the branch and the jump left the fall-through path. Idle cycles with the load enable low, addressing a different memory word, show that the instruction register holds its value.

// File: rtl/mcd_pkg.sv
`timescale 1ns/1ps
package mcd_pkg;
   typedef enum logic [2:0] {
      ALU_AND = 3'b000,
      ALU_OR  = 3'b001,
      ALU_ADD = 3'b010,
      ALU_SUB = 3'b110,
      ALU_SLT = 3'b111
   } alu_op_e;

   typedef enum logic [1:0] {
      OPB_REG    = 2'b00,
      OPB_FOUR   = 2'b01,
      OPB_IMM    = 2'b10,
      OPB_IMM_X4 = 2'b11
   } opb_sel_e;

   typedef enum logic [1:0] {
      NPC_LIVE = 2'b00,
      NPC_HELD = 2'b01,
      NPC_JUMP = 2'b10
   } npc_sel_e;

   localparam int unsigned OP_W   = 6;
   localparam int unsigned FN_W   = 6;
   localparam int unsigned RS_LSB = 21;
   localparam int unsigned RT_LSB = 16;
   localparam int unsigned RD_LSB = 11;
   localparam int unsigned IMM_W  = 16;
   localparam int unsigned JIDX_W = 26;
   localparam int unsigned SEG_W  = 4;
endpackage

// File: rtl/mcd_alu.sv
`timescale 1ns/1ps
module mcd_alu
   import mcd_pkg::*;
#(
   parameter int unsigned XLEN       = 32,
   parameter bit          SIGNED_SLT = 1'b1
) (
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   input  alu_op_e         op,
   output logic [XLEN-1:0] y,
   output logic            zero
);
   logic            lt;
   logic            is_sub;
   logic [XLEN-1:0] b_eff;
   logic [XLEN-1:0] sum;

   generate
      if (SIGNED_SLT) begin : g_slt_signed
         assign lt = $signed(a) < $signed(b);
      end else begin : g_slt_unsigned
         assign lt = a < b;
      end
   endgenerate

   // one adder serves both add and subtract
   assign is_sub = (op == ALU_SUB);
   assign b_eff  = is_sub ? ~b : b;
   assign sum    = a + b_eff + {{(XLEN-1){1'b0}}, is_sub};

   always_comb begin
      case (op)
         ALU_AND: y = a & b;
         ALU_OR:  y = a | b;
         ALU_ADD: y = sum;
         ALU_SUB: y = sum;
         ALU_SLT: y = {{(XLEN-1){1'b0}}, lt};
         default: y = '0;
      endcase
   end

   assign zero = (y == '0);
endmodule

// File: rtl/mcd_regfile.sv
`timescale 1ns/1ps
module mcd_regfile #(
   parameter int unsigned XLEN     = 32,
   parameter int unsigned NREGS    = 32,
   parameter int unsigned AW       = $clog2(NREGS),
   parameter bit          ZERO_REG = 1'b1
) (
   input  logic            clk,
   input  logic            we,
   input  logic [AW-1:0]   ra1,
   input  logic [AW-1:0]   ra2,
   input  logic [AW-1:0]   wa,
   input  logic [XLEN-1:0] wd,
   output logic [XLEN-1:0] rd1,
   output logic [XLEN-1:0] rd2
);
   logic [XLEN-1:0] regs [NREGS];

   always_ff @(posedge clk) begin
      if (we && (!ZERO_REG || wa != '0)) begin
         regs[wa] <= wd;
      end
   end

   generate
      if (ZERO_REG) begin : g_hard_zero
         assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
         assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
      end else begin : g_plain
         assign rd1 = regs[ra1];
         assign rd2 = regs[ra2];
      end
   endgenerate
endmodule

// File: rtl/mcd_operands.sv
`timescale 1ns/1ps
module mcd_operands
   import mcd_pkg::*;
#(
   parameter int unsigned XLEN = 32
) (
   input  logic [XLEN-1:0]   pc,
   input  logic [JIDX_W-1:0] jidx,
   input  logic [XLEN-1:0]   a_reg,
   input  logic [XLEN-1:0]   b_reg,
   input  logic [XLEN-1:0]   alu_y,
   input  logic [XLEN-1:0]   alu_held,
   input  logic              opa_sel,
   input  opb_sel_e          opb_sel,
   input  npc_sel_e          npc_sel,
   output logic [XLEN-1:0]   src_a,
   output logic [XLEN-1:0]   src_b,
   output logic [XLEN-1:0]   pc_next
);
   logic [XLEN-1:0] imm_ext;
   logic [XLEN-1:0] imm_x4;
   logic [XLEN-1:0] jump_tgt;

   assign imm_ext  = {{(XLEN-IMM_W){jidx[IMM_W-1]}}, jidx[IMM_W-1:0]};
   assign imm_x4   = {imm_ext[XLEN-3:0], 2'b00};
   assign jump_tgt = {pc[XLEN-1 -: SEG_W], jidx, 2'b00};

   assign src_a = opa_sel ? a_reg : pc;

   always_comb begin
      case (opb_sel)
         OPB_REG:    src_b = b_reg;
         OPB_FOUR:   src_b = XLEN'(4);
         OPB_IMM:    src_b = imm_ext;
         OPB_IMM_X4: src_b = imm_x4;
         default:    src_b = b_reg;
      endcase
   end

   always_comb begin
      case (npc_sel)
         NPC_LIVE: pc_next = alu_y;
         NPC_HELD: pc_next = alu_held;
         NPC_JUMP: pc_next = jump_tgt;
         default:  pc_next = alu_y;
      endcase
   end
endmodule

// File: rtl/mc_datapath.sv
`timescale 1ns/1ps
module mc_datapath
   import mcd_pkg::*;
#(
   parameter int unsigned     XLEN       = 32,
   parameter int unsigned     NREGS      = 32,
   parameter logic [XLEN-1:0] RESET_PC   = '0,
   parameter bit              ZERO_REG   = 1'b1,
   parameter bit              SIGNED_SLT = 1'b1
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        pc_wr,
   input  logic        br_cond,
   input  logic        ir_ld,
   input  logic        addr_sel,
   input  logic        st_en,
   input  logic        rf_we,
   input  logic        rd_sel,
   input  logic        wb_sel,
   input  logic        opa_sel,
   input  logic [1:0]  opb_sel,
   input  logic [1:0]  npc_sel,
   input  logic [2:0]  alu_op,
   input  logic [31:0] mem_rdata,
   output logic [31:0] mem_addr,
   output logic [31:0] mem_wdata,
   output logic        mem_wr,
   output logic [5:0]  op_field,
   output logic [5:0]  fn_field,
   output logic        alu_zero
);
   localparam int unsigned RAW = $clog2(NREGS);

   generate
      if (XLEN != 32) begin : g_bad_xlen
         $error("mc_datapath: instruction fields need XLEN of 32");
      end
      if (NREGS < 2 || NREGS > 32 || (NREGS & (NREGS - 1)) != 0) begin : g_bad_nregs
         $error("mc_datapath: NREGS must be a power of two from 2 to 32");
      end
      if (RESET_PC[1:0] != 2'b00) begin : g_bad_reset_pc
         $error("mc_datapath: RESET_PC must be word aligned");
      end
   endgenerate

   logic [XLEN-1:0] pc_q;
   logic [XLEN-1:0] ir_q;
   logic [XLEN-1:0] data_q;
   logic [XLEN-1:0] a_q;
   logic [XLEN-1:0] b_q;
   logic [XLEN-1:0] aluout_q;

   logic [XLEN-1:0] rd1;
   logic [XLEN-1:0] rd2;
   logic [XLEN-1:0] src_a;
   logic [XLEN-1:0] src_b;
   logic [XLEN-1:0] alu_y;
   logic [XLEN-1:0] pc_next;
   logic [XLEN-1:0] wb_data;
   logic [RAW-1:0]  wb_addr;
   logic            zero_int;
   logic            pc_en;

   assign pc_en   = pc_wr | (br_cond & zero_int);
   assign wb_addr = rd_sel ? ir_q[RD_LSB +: RAW] : ir_q[RT_LSB +: RAW];
   assign wb_data = wb_sel ? data_q : aluout_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q     <= RESET_PC;
         ir_q     <= '0;
         data_q   <= '0;
         a_q      <= '0;
         b_q      <= '0;
         aluout_q <= '0;
      end else begin
         if (pc_en) pc_q <= pc_next;
         if (ir_ld) ir_q <= mem_rdata;
         data_q   <= mem_rdata;
         a_q      <= rd1;
         b_q      <= rd2;
         aluout_q <= alu_y;
      end
   end

   mcd_regfile #(
      .XLEN     (XLEN),
      .NREGS    (NREGS),
      .AW       (RAW),
      .ZERO_REG (ZERO_REG)
   ) i_regfile (
      .clk (clk),
      .we  (rf_we),
      .ra1 (ir_q[RS_LSB +: RAW]),
      .ra2 (ir_q[RT_LSB +: RAW]),
      .wa  (wb_addr),
      .wd  (wb_data),
      .rd1 (rd1),
      .rd2 (rd2)
   );

   mcd_operands #(
      .XLEN (XLEN)
   ) i_operands (
      .pc       (pc_q),
      .jidx     (ir_q[JIDX_W-1:0]),
      .a_reg    (a_q),
      .b_reg    (b_q),
      .alu_y    (alu_y),
      .alu_held (aluout_q),
      .opa_sel  (opa_sel),
      .opb_sel  (opb_sel_e'(opb_sel)),
      .npc_sel  (npc_sel_e'(npc_sel)),
      .src_a    (src_a),
      .src_b    (src_b),
      .pc_next  (pc_next)
   );

   mcd_alu #(
      .XLEN       (XLEN),
      .SIGNED_SLT (SIGNED_SLT)
   ) i_alu (
      .a    (src_a),
      .b    (src_b),
      .op   (alu_op_e'(alu_op)),
      .y    (alu_y),
      .zero (zero_int)
   );

   assign mem_addr  = addr_sel ? aluout_q : pc_q;
   assign mem_wdata = b_q;
   assign mem_wr    = st_en;
   assign op_field  = ir_q[XLEN-1 -: OP_W];
   assign fn_field  = ir_q[FN_W-1:0];
   assign alu_zero  = zero_int;
endmodule

// File: rtl/mcd_datapath_chk.sv
`timescale 1ns/1ps
module mcd_datapath_chk #(
   parameter int unsigned     XLEN     = 32,
   parameter logic [XLEN-1:0] RESET_PC = '0,
   parameter bit              ZERO_REG = 1'b1
) (
   input logic            clk,
   input logic            rst,
   input logic            pc_wr,
   input logic            br_cond,
   input logic            ir_ld,
   input logic            opa_sel,
   input logic [1:0]      opb_sel,
   input logic [1:0]      npc_sel,
   input logic [2:0]      alu_op,
   input logic            alu_zero,
   input logic [31:0]     mem_rdata,
   input logic [XLEN-1:0] pc_q,
   input logic [XLEN-1:0] ir_q,
   input logic [XLEN-1:0] a_q,
   input logic [XLEN-1:0] b_q
);
   p_pc_reset_r1: assert property (@(posedge clk)
      rst |=> pc_q == RESET_PC);

   p_ir_load_r3: assert property (@(posedge clk) disable iff (rst)
      ir_ld |=> ir_q == $past(mem_rdata));

   p_ir_hold_r3: assert property (@(posedge clk) disable iff (rst)
      !ir_ld |=> $stable(ir_q));

   p_pc_hold_r10: assert property (@(posedge clk) disable iff (rst)
      (!pc_wr && !(br_cond && alu_zero)) |=> $stable(pc_q));

   p_pc_step_r9: assert property (@(posedge clk) disable iff (rst)
      (pc_wr && npc_sel == 2'b00 && !opa_sel && opb_sel == 2'b01 && alu_op == 3'b010)
      |=> pc_q == $past(pc_q) + XLEN'(4));

   p_sub_equal_zero_r8: assert property (@(posedge clk) disable iff (rst)
      (alu_op == 3'b110 && opa_sel && opb_sel == 2'b00 && a_q == b_q) |-> alu_zero);

   generate
      if (ZERO_REG) begin : g_r0
         p_r0_reads_zero_r4: assert property (@(posedge clk) disable iff (rst)
            (ir_q[25:21] == 5'd0) |=> a_q == '0);
      end
   endgenerate
endmodule

bind mc_datapath mcd_datapath_chk #(
   .XLEN     (XLEN),
   .RESET_PC (RESET_PC),
   .ZERO_REG (ZERO_REG)
) i_chk (
   .clk       (clk),
   .rst       (rst),
   .pc_wr     (pc_wr),
   .br_cond   (br_cond),
   .ir_ld     (ir_ld),
   .opa_sel   (opa_sel),
   .opb_sel   (opb_sel),
   .npc_sel   (npc_sel),
   .alu_op    (alu_op),
   .alu_zero  (alu_zero),
   .mem_rdata (mem_rdata),
   .pc_q      (pc_q),
   .ir_q      (ir_q),
   .a_q       (a_q),
   .b_q       (b_q)
);

// File: tb/test_mc_datapath.sv
`timescale 1ns/1ps
module test_mc_datapath;
   typedef struct packed {
      logic       pcw;
      logic       br;
      logic       irw;
      logic       iord;
      logic       mw;
      logic       rw;
      logic       rd;
      logic       m2r;
      logic       sa;
      logic [1:0] sb;
      logic [1:0] ps;
      logic [2:0] ac;
   } ctl_t;

   localparam logic [5:0] OPC_R    = 6'd0;
   localparam logic [5:0] OPC_J    = 6'd2;
   localparam logic [5:0] OPC_BEQ  = 6'd4;
   localparam logic [5:0] OPC_ADDI = 6'd8;
   localparam logic [5:0] OPC_LW   = 6'd35;
   localparam logic [5:0] OPC_SW   = 6'd43;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        pc_wr = 1'b0, br_cond = 1'b0, ir_ld = 1'b0, addr_sel = 1'b0;
   logic        st_en = 1'b0, rf_we = 1'b0, rd_sel = 1'b0, wb_sel = 1'b0, opa_sel = 1'b0;
   logic [1:0]  opb_sel = 2'b00, npc_sel = 2'b00;
   logic [2:0]  alu_op = 3'b000;
   logic [31:0] mem_rdata;
   logic [31:0] mem_addr, mem_wdata;
   logic        mem_wr;
   logic [5:0]  op_field, fn_field;
   logic        alu_zero;

   logic [31:0] mem [0:63];
   int          n_chk = 0;
   int          n_fail = 0;
   bit          done = 1'b0;
   logic        last_zero;

   always #4 clk = ~clk;

   assign mem_rdata = mem[mem_addr[7:2]];
   always @(posedge clk) begin
      if (mem_wr) mem[mem_addr[7:2]] <= mem_wdata;
   end

   mc_datapath i_mc_datapath (
      .clk       (clk),
      .rst       (rst),
      .pc_wr     (pc_wr),
      .br_cond   (br_cond),
      .ir_ld     (ir_ld),
      .addr_sel  (addr_sel),
      .st_en     (st_en),
      .rf_we     (rf_we),
      .rd_sel    (rd_sel),
      .wb_sel    (wb_sel),
      .opa_sel   (opa_sel),
      .opb_sel   (opb_sel),
      .npc_sel   (npc_sel),
      .alu_op    (alu_op),
      .mem_rdata (mem_rdata),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_wr    (mem_wr),
      .op_field  (op_field),
      .fn_field  (fn_field),
      .alu_zero  (alu_zero)
   );

   function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs, logic [4:0] rt, logic [15:0] imm);
      return {op, rs, rt, imm};
   endfunction

   function automatic logic [31:0] enc_r(logic [4:0] rs, logic [4:0] rt, logic [4:0] rd, logic [5:0] fn);
      return {OPC_R, rs, rt, rd, 5'd0, fn};
   endfunction

   function automatic logic [2:0] alu_of(logic [5:0] fn);
      case (fn)
         6'h20:   return 3'b010;
         6'h22:   return 3'b110;
         6'h24:   return 3'b000;
         6'h25:   return 3'b001;
         6'h2A:   return 3'b111;
         default: return 3'b010;
      endcase
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic apply(input ctl_t c);
      @(negedge clk);
      pc_wr    = c.pcw;
      br_cond  = c.br;
      ir_ld    = c.irw;
      addr_sel = c.iord;
      st_en    = c.mw;
      rf_we    = c.rw;
      rd_sel   = c.rd;
      wb_sel   = c.m2r;
      opa_sel  = c.sa;
      opb_sel  = c.sb;
      npc_sel  = c.ps;
      alu_op   = c.ac;
      #1;
   endtask

   task automatic idle();
      apply('0);
   endtask

   // bench-side sequencer: one instruction, with checks along the way
   task automatic run_instr(input int idx);
      ctl_t        c;
      logic [31:0] iw;
      logic [31:0] sext;
      c = '0; c.pcw = 1'b1; c.irw = 1'b1; c.sb = 2'b01; c.ac = 3'b010;
      apply(c);
      chk($sformatf("R1 R6 R9 fetch address, word %0d", idx), mem_addr, 32'(idx * 4));
      iw   = mem[idx];
      sext = {{16{iw[15]}}, iw[15:0]};
      c = '0; c.sb = 2'b11; c.ac = 3'b010;
      apply(c);
      chk("R3 opcode field", {26'd0, op_field}, {26'd0, iw[31:26]});
      chk("R3 function field", {26'd0, fn_field}, {26'd0, iw[5:0]});
      case (iw[31:26])
         OPC_LW: begin
            c = '0; c.sa = 1'b1; c.sb = 2'b10; c.ac = 3'b010; apply(c);
            c = '0; c.iord = 1'b1; apply(c);
            if (iw[25:21] == 5'd0) chk("R2 R7 load address", mem_addr, sext);
            c = '0; c.rw = 1'b1; c.m2r = 1'b1; apply(c);
         end
         OPC_SW: begin
            c = '0; c.sa = 1'b1; c.sb = 2'b10; c.ac = 3'b010; apply(c);
            c = '0; c.iord = 1'b1; c.mw = 1'b1; apply(c);
            if (iw[25:21] == 5'd0) chk("R2 R7 store address", mem_addr, sext);
            chk("R11 write strobe", {31'd0, mem_wr}, 32'd1);
         end
         OPC_R: begin
            c = '0; c.sa = 1'b1; c.sb = 2'b00; c.ac = alu_of(iw[5:0]); apply(c);
            c = '0; c.rd = 1'b1; c.rw = 1'b1; apply(c);
         end
         OPC_ADDI: begin
            c = '0; c.sa = 1'b1; c.sb = 2'b10; c.ac = 3'b010; apply(c);
            c = '0; c.rw = 1'b1; apply(c);
         end
         OPC_BEQ: begin
            c = '0; c.sa = 1'b1; c.sb = 2'b00; c.ac = 3'b110; c.ps = 2'b01; c.br = 1'b1;
            apply(c);
            last_zero = alu_zero;
         end
         OPC_J: begin
            c = '0; c.ps = 2'b10; c.pcw = 1'b1; apply(c);
         end
         default: chk("R3 unexpected opcode", {26'd0, iw[31:26]}, 32'd0);
      endcase
   endtask

   task automatic t_reset();
      idle();
      chk("R1 PC after reset", mem_addr, 32'd0);
      chk("R11 no write when idle", {31'd0, mem_wr}, 32'd0);
   endtask

   task automatic t_alu_program();
      for (int k = 0; k <= 15; k++) run_instr(k);
      idle();
      chk("R8 R5 add result",             mem[34], 32'd4);
      chk("R8 subtract result",           mem[35], 32'd10);
      chk("R8 AND result",                mem[36], 32'd5);
      chk("R8 OR result",                 mem[37], 32'hFFFF_FFFF);
      chk("R8 signed compare true",       mem[38], 32'd1);
      chk("R7 R5 negative immediate add", mem[39], 32'hFFFF_FFFF);
      chk("R4 register 0 write ignored",  mem[40], 32'd0);
   endtask

   task automatic t_branch_jump();
      run_instr(16);
      chk("R8 R10 zero low on unequal", {31'd0, last_zero}, 32'd0);
      run_instr(17);
      chk("R8 R10 zero high on equal", {31'd0, last_zero}, 32'd1);
      run_instr(20);
      run_instr(24);
      run_instr(25);
      idle();
      chk("R8 signed compare false", mem[42], 32'd0);
      chk("R10 R9 skipped slot untouched", mem[41], 32'h0000_0011);
   endtask

   task automatic t_ir_hold();
      ctl_t c;
      c = '0; c.iord = 1'b1;
      apply(c);
      apply(c);
      chk("R3 opcode held without load", {26'd0, op_field}, {26'd0, OPC_SW});
      chk("R3 function held without load", {26'd0, fn_field}, 32'd40);
      chk("R11 no write without request", {31'd0, mem_wr}, 32'd0);
      chk("R11 data unchanged", mem[42], 32'd0);
   endtask

   initial begin
      for (int k = 0; k < 64; k++) mem[k] = 32'd0;
      mem[0]  = enc_i(OPC_LW, 5'd0, 5'd1, 16'd128);
      mem[1]  = enc_i(OPC_LW, 5'd0, 5'd2, 16'd132);
      mem[2]  = enc_r(5'd1, 5'd2, 5'd3, 6'h20);
      mem[3]  = enc_r(5'd1, 5'd2, 5'd4, 6'h22);
      mem[4]  = enc_r(5'd1, 5'd2, 5'd5, 6'h24);
      mem[5]  = enc_r(5'd1, 5'd2, 5'd6, 6'h25);
      mem[6]  = enc_r(5'd2, 5'd1, 5'd7, 6'h2A);
      mem[7]  = enc_i(OPC_ADDI, 5'd1, 5'd8, 16'hFFF8);
      mem[8]  = enc_i(OPC_ADDI, 5'd1, 5'd0, 16'd5);
      mem[9]  = enc_i(OPC_SW, 5'd0, 5'd3, 16'd136);
      mem[10] = enc_i(OPC_SW, 5'd0, 5'd4, 16'd140);
      mem[11] = enc_i(OPC_SW, 5'd0, 5'd5, 16'd144);
      mem[12] = enc_i(OPC_SW, 5'd0, 5'd6, 16'd148);
      mem[13] = enc_i(OPC_SW, 5'd0, 5'd7, 16'd152);
      mem[14] = enc_i(OPC_SW, 5'd0, 5'd8, 16'd156);
      mem[15] = enc_i(OPC_SW, 5'd0, 5'd0, 16'd160);
      mem[16] = enc_i(OPC_BEQ, 5'd1, 5'd2, 16'd5);
      mem[17] = enc_i(OPC_BEQ, 5'd1, 5'd1, 16'd2);
      mem[18] = enc_i(OPC_SW, 5'd0, 5'd1, 16'd164);
      mem[19] = enc_i(OPC_SW, 5'd0, 5'd1, 16'd164);
      mem[20] = {OPC_J, 26'd24};
      mem[21] = enc_i(OPC_SW, 5'd0, 5'd1, 16'd164);
      mem[22] = enc_i(OPC_SW, 5'd0, 5'd1, 16'd164);
      mem[23] = enc_i(OPC_SW, 5'd0, 5'd1, 16'd164);
      mem[24] = enc_r(5'd1, 5'd2, 5'd9, 6'h2A);
      mem[25] = enc_i(OPC_SW, 5'd0, 5'd9, 16'd168);
      mem[32] = 32'd7;
      mem[33] = 32'hFFFF_FFFD;
      mem[40] = 32'h0000_DEAD;
      mem[41] = 32'h0000_0011;
      mem[42] = 32'h0000_0055;

      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;

      t_reset();
      t_alu_program();
      t_branch_jump();
      t_ir_hold();

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #1600000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule